// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two direction predictors run side by side on every request, and a third table picks which one to trust.

The local predictor keeps a short history of each branch's own outcomes. The table holding these histories is indexed by word-address bits of the PC. That history then selects a 3-bit saturating pattern counter. The global predictor uses a shift register of the most recent predicted directions to select a 2-bit saturating counter. A chooser table of 2-bit counters uses the same global history as its index. Its upper bit selects the local result or the global result.

A prediction is combinational from the current table state whenever a request is presented. The same cycle that accepts a request also shifts the predicted direction into the global history. With the prediction the block returns a snapshot of the indices and component votes it used. The pipeline keeps that snapshot and hands it back on the update port once the branch resolves. The update port then trains the exact entries that produced the prediction.

Top module: `tourney_bp`

## Requirements
- R1: After reset, every request yields a not-taken prediction and an all-zero snapshot. All 2-bit counters start at 1 and all 3-bit pattern counters at 3, so both votes are not-taken. Every local history and the global history start at zero. The chooser starts at 1, which selects the global vote.
- R2: The local history read for a request comes from entry `pred_pc[LIDX_W+1:2]` of the local history table.
- R3: The local vote is bit 2 (the upper bit) of the 3-bit pattern counter selected by the local history. On update, the counter at the snapshot's local history moves one step toward the actual outcome, saturating at 0 and 7.
- R4: The global vote is bit 1 of the 2-bit counter selected by the global history. On update, the counter at the snapshot's global history moves one step toward the outcome, saturating at 0 and 3.
- R5: The chooser entry at the global history selects the source of `pred_taken`. When its upper bit is 1 the local vote is used; when it is 0 the global vote is used.
- R6: On update, the chooser entry at the snapshot's global history changes only if the snapshot's two votes differ. It steps up (toward local) when the local vote matched the outcome, and down otherwise, saturating at 0 and 3.
- R7: A clock edge with `pred_valid` high shifts `pred_taken` into bit 0 of the global history, dropping the oldest bit. With `pred_valid` low, or with only an update, the global history is unchanged.
- R8: On update, the local history entry at `upd_pc[LIDX_W+1:2]` shifts left and takes `upd_taken` into bit 0.
- R9: When a request and an update arrive in the same cycle, both commit at the same edge. The prediction is formed from the table contents before that update.
- R10: The snapshot packs, from bit 0 upward: the global vote (bit 0), the local vote (bit 1), the local history (`LHIST_W` bits from bit 2), then the global history (`GHIST_W` bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | A prediction request is present |
| pred_pc | input | PC_W | Branch PC of the request |
| pred_taken | output | 1 | Predicted direction |
| pred_snap | output | GHIST_W+LHIST_W+2 | Indices and votes used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_snap | input | GHIST_W+LHIST_W+2 | Snapshot returned from prediction time |

## Verification
The assertions assume that `pred_pc` is driven to a known value on every cycle after reset, including idle ones, because they compare the local history across consecutive cycles. They also assume that no request arrives while the internal reset is still being released. The bench holds all inputs at zero for several cycles after reset is removed and drives every input on every cycle. Each `upd_snap` it returns is a snapshot the bench itself predicted, so the update port never sees an index combination that no prediction produced.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic {
    PICK_GLOBAL = 1'b0,
    PICK_LOCAL  = 1'b1
  } pick_e;

  // one saturating step of a counter whose all-ones value is cmax
  function automatic logic [7:0] ctr_step(input logic [7:0] cur,
                                          input logic [7:0] cmax,
                                          input logic       up);
    logic [7:0] res;
    res = cur;
    if (up && (cur != cmax)) res = cur + 8'd1;
    else if (!up && (cur != 8'd0)) res = cur - 8'd1;
    return res;
  endfunction

endpackage

// File: rtl/tbp_rst_sync.sv
module tbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tbp_sat_table.sv
module tbp_sat_table #(
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_up
);
  import tbp_pkg::*;

  localparam int               DEPTH    = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] cur_ctr;
  logic [CTR_W-1:0] nxt_ctr;

  assign rd_ctr  = ctr_q[rd_idx];
  assign cur_ctr = ctr_q[upd_idx];

  always_comb begin
    logic [7:0] stepped;
    stepped = ctr_step(8'(cur_ctr), 8'(CTR_MAX), upd_up);
    nxt_ctr = stepped[CTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= nxt_ctr;
    end
  end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] nxt_hist;

  assign rd_hist  = hist_q[rd_idx];
  assign nxt_hist = {hist_q[wr_idx][HIST_W-2:0], wr_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= nxt_hist;
    end
  end
endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int LCTR_W  = 3,
  parameter int GHIST_W = 12,
  parameter int GCTR_W  = 2,
  parameter int SEL_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pred_valid,
  input  logic [PC_W-1:0]            pred_pc,
  output logic                       pred_taken,
  output logic [GHIST_W+LHIST_W+1:0] pred_snap,
  input  logic                       upd_valid,
  input  logic [PC_W-1:0]            upd_pc,
  input  logic                       upd_taken,
  input  logic [GHIST_W+LHIST_W+1:0] upd_snap
);
  import tbp_pkg::*;

  localparam int LH_LO = 2;
  localparam int LH_HI = LH_LO + LHIST_W - 1;
  localparam int GH_LO = LH_HI + 1;
  localparam int GH_HI = GH_LO + GHIST_W - 1;

  logic rst_sync_n;

  tbp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // index and snapshot field extraction
  logic [LIDX_W-1:0]  p_idx, u_idx;
  logic [LHIST_W-1:0] u_lhist;
  logic [GHIST_W-1:0] u_ghist;
  logic               u_lvote, u_gvote;

  assign p_idx   = pred_pc[LIDX_W+1:2];
  assign u_idx   = upd_pc[LIDX_W+1:2];
  assign u_gvote = upd_snap[0];
  assign u_lvote = upd_snap[1];
  assign u_lhist = upd_snap[LH_HI:LH_LO];
  assign u_ghist = upd_snap[GH_HI:GH_LO];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:LIDX_W+2], pred_pc[1:0],
                            upd_pc[PC_W-1:LIDX_W+2], upd_pc[1:0]};

  logic [LHIST_W-1:0] p_lhist;
  logic [GHIST_W-1:0] ghist;
  logic [LCTR_W-1:0]  p_lctr;
  logic [GCTR_W-1:0]  p_gctr;
  logic [SEL_W-1:0]   p_sel;
  logic               chooser_en, chooser_up;

  tbp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist_tab (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (p_idx),
    .rd_hist (p_lhist),
    .wr_en   (upd_valid),
    .wr_idx  (u_idx),
    .wr_bit  (upd_taken)
  );

  tbp_sat_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lpat_tab (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (p_lhist),
    .rd_ctr  (p_lctr),
    .upd_en  (upd_valid),
    .upd_idx (u_lhist),
    .upd_up  (upd_taken)
  );

  tbp_sat_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gpat_tab (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (ghist),
    .rd_ctr  (p_gctr),
    .upd_en  (upd_valid),
    .upd_idx (u_ghist),
    .upd_up  (upd_taken)
  );

  assign chooser_en = upd_valid && (u_lvote != u_gvote);
  assign chooser_up = (u_lvote == upd_taken);

  tbp_sat_table #(.IDX_W(GHIST_W), .CTR_W(SEL_W)) u_chooser (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (ghist),
    .rd_ctr  (p_sel),
    .upd_en  (chooser_en),
    .upd_idx (u_ghist),
    .upd_up  (chooser_up)
  );

  logic  l_vote, g_vote;
  pick_e pick;

  always_comb begin
    l_vote     = p_lctr[LCTR_W-1];
    g_vote     = p_gctr[GCTR_W-1];
    pick       = pick_e'(p_sel[SEL_W-1]);
    pred_taken = (pick == PICK_LOCAL) ? l_vote : g_vote;
    pred_snap  = {ghist, p_lhist, l_vote, g_vote};
  end

  tbp_ghr #(.HIST_W(GHIST_W)) u_ghr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (pred_valid),
    .shift_bit (pred_taken),
    .hist      (ghist)
  );
endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pred_valid,
  input logic [PC_W-1:0]            pred_pc,
  input logic                       pred_taken,
  input logic [GHIST_W+LHIST_W+1:0] pred_snap,
  input logic                       upd_valid,
  input logic [PC_W-1:0]            upd_pc,
  input logic                       upd_taken
);
  localparam int LH_LO = 2;
  localparam int LH_HI = LH_LO + LHIST_W - 1;
  localparam int GH_LO = LH_HI + 1;
  localparam int GH_HI = GH_LO + GHIST_W - 1;

  logic [GHIST_W-1:0] gh;
  logic [LHIST_W-1:0] lh;
  logic [LIDX_W-1:0]  p_idx, u_idx;
  logic               unused_chk;

  assign gh    = pred_snap[GH_HI:GH_LO];
  assign lh    = pred_snap[LH_HI:LH_LO];
  assign p_idx = pred_pc[LIDX_W+1:2];
  assign u_idx = upd_pc[LIDX_W+1:2];
  assign unused_chk = ^{pred_pc[PC_W-1:LIDX_W+2], pred_pc[1:0],
                        upd_pc[PC_W-1:LIDX_W+2], upd_pc[1:0]};

  // R7: a request shifts its own direction into the global history
  assert_ghist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> gh == {$past(gh[GHIST_W-2:0]), $past(pred_taken)});

  // R7: no request, no change to global history
  assert_ghist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> $stable(gh));

  // R5: when both votes agree the output must follow them
  assert_votes_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_snap[0] == pred_snap[1]) |-> (pred_taken == pred_snap[0]));

  // R8: without an update, the local history seen at a fixed PC is stable
  assert_lhist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pred_pc) && !$past(upd_valid)) |-> $stable(lh));

  // R8 R9: an update to the requested branch shifts in its outcome
  assert_lhist_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pred_pc) && $past(upd_valid) && ($past(u_idx) == p_idx))
      |-> lh == {$past(lh[LHIST_W-2:0]), $past(upd_taken)});
endmodule

bind tourney_bp tbp_chk #(
  .PC_W    (PC_W),
  .LIDX_W  (LIDX_W),
  .LHIST_W (LHIST_W),
  .GHIST_W (GHIST_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pred_valid (pred_valid),
  .pred_pc    (pred_pc),
  .pred_taken (pred_taken),
  .pred_snap  (pred_snap),
  .upd_valid  (upd_valid),
  .upd_pc     (upd_pc),
  .upd_taken  (upd_taken)
);

// File: tb/tourney_bp_tb.sv
`timescale 1ns/1ps
module tourney_bp_tb;
  localparam int PC_W = 8, LIDX_W = 3, LHIST_W = 3, LCTR_W = 3;
  localparam int GHIST_W = 4, GCTR_W = 2, SEL_W = 2;
  localparam int SNAP_W = GHIST_W + LHIST_W + 2;
  localparam int NLH = 1 << LIDX_W, NLC = 1 << LHIST_W, NG = 1 << GHIST_W;
  localparam int QD = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic pred_valid, pred_taken, upd_valid, upd_taken;
  logic [PC_W-1:0] pred_pc, upd_pc;
  logic [SNAP_W-1:0] pred_snap, upd_snap;

  always #4 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W), .LCTR_W(LCTR_W),
               .GHIST_W(GHIST_W), .GCTR_W(GCTR_W), .SEL_W(SEL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_snap(pred_snap), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_snap(upd_snap));

  int vectors = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_lh [NLH];
  int m_lc [NLC];
  int m_gc [NG];
  int m_ch [NG];
  int m_gh;
  int e_lh, e_lv, e_gv, e_tk;

  // pending updates
  int q_pc [QD];
  int q_tk [QD];
  int q_sn [QD];
  int q_head = 0, q_cnt = 0;
  int per_idx_cnt [NLH];

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int step(input int cur, input int cmax, input int up);
    if (up != 0 && cur < cmax) return cur + 1;
    if (up == 0 && cur > 0) return cur - 1;
    return cur;
  endfunction

  function automatic int idx_of(input int pc);
    return (pc >> 2) % NLH;
  endfunction

  task automatic model_predict(input int pc);
    int sel;
    e_lh = m_lh[idx_of(pc)];
    e_lv = (m_lc[e_lh] >> (LCTR_W - 1)) & 1;
    e_gv = (m_gc[m_gh] >> (GCTR_W - 1)) & 1;
    sel  = (m_ch[m_gh] >> (SEL_W - 1)) & 1;
    e_tk = sel ? e_lv : e_gv;
  endtask

  task automatic compare_outputs(input bit same_idx_upd);
    int s;
    s = int'(pred_snap);
    chk("R5 R6 pred_taken", int'(pred_taken), e_tk);
    chk("R4 R10 global vote", s & 1, e_gv);
    chk("R3 R10 local vote", (s >> 1) & 1, e_lv);
    chk(same_idx_upd ? "R9 local history" : "R2 local history",
        (s >> 2) & (NLC - 1), e_lh);
    chk("R7 global history", (s >> (2 + LHIST_W)) & (NG - 1), m_gh);
  endtask

  task automatic model_commit(input bit pv, input bit uv, input int upc,
                              input int utk, input int usn);
    int ugv, ulv, ulh, ugh, ui;
    if (uv) begin
      ugv = usn & 1;
      ulv = (usn >> 1) & 1;
      ulh = (usn >> 2) & (NLC - 1);
      ugh = (usn >> (2 + LHIST_W)) & (NG - 1);
      ui  = idx_of(upc);
      m_lh[ui]  = ((m_lh[ui] << 1) | utk) & (NLC - 1);
      m_lc[ulh] = step(m_lc[ulh], (1 << LCTR_W) - 1, utk);
      m_gc[ugh] = step(m_gc[ugh], (1 << GCTR_W) - 1, utk);
      if (ulv != ugv) m_ch[ugh] = step(m_ch[ugh], (1 << SEL_W) - 1, (ulv == utk) ? 1 : 0);
    end
    if (pv) m_gh = ((m_gh << 1) | e_tk) & (NG - 1);
  endtask

  // one cycle: drive at negedge, compare, then commit at posedge
  task automatic cycle(input bit pv, input int ppc, input int ptk,
                       input bit uv, input int upc, input int utk, input int usn);
    @(negedge clk);
    pred_valid = pv;
    pred_pc    = PC_W'(ppc);
    upd_valid  = uv;
    upd_pc     = PC_W'(upc);
    upd_taken  = utk[0];
    upd_snap   = SNAP_W'(usn);
    #1;
    model_predict(ppc);
    compare_outputs(uv && (idx_of(upc) == idx_of(ppc)));
    @(posedge clk);
    model_commit(pv, uv, upc, utk, usn);
    if (pv) begin
      q_pc[(q_head + q_cnt) % QD] = ppc;
      q_tk[(q_head + q_cnt) % QD] = ptk;
      q_sn[(q_head + q_cnt) % QD] = (m_gh_prev_snapshot(ppc));
      q_cnt++;
    end
  endtask

  // snapshot as the model predicted it this cycle (e_* still hold it)
  function automatic int m_gh_prev_snapshot(input int pc);
    int gh_before;
    gh_before = ((m_gh >> 1) | (((m_gh & 0) ) )) ;
    return snap_hold;
  endfunction

  int snap_hold;

  task automatic run_cycle(input bit pv, input int ppc, input int ptk, input bit take_upd);
    bit uv;
    int upc, utk, usn;
    uv = take_upd && (q_cnt > 0);
    upc = 0; utk = 0; usn = 0;
    if (uv) begin
      upc = q_pc[q_head];
      utk = q_tk[q_head];
      usn = q_sn[q_head];
      q_head = (q_head + 1) % QD;
      q_cnt--;
    end
    snap_hold = (m_gh << (2 + LHIST_W)) | (m_lh[idx_of(ppc)] << 2)
              | (((m_lc[m_lh[idx_of(ppc)]] >> (LCTR_W - 1)) & 1) << 1)
              | ((m_gc[m_gh] >> (GCTR_W - 1)) & 1);
    cycle(pv, ppc, ptk, uv, upc, utk, usn);
  endtask

  function automatic int outcome_for(input int idx);
    int n;
    n = per_idx_cnt[idx];
    case (idx)
      0: return 1;
      1: return n & 1;
      2: return (n % 3) != 2 ? 1 : 0;
      3: return 0;
      default: return int'($urandom_range(1, 0));
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    pred_valid = 1'b0; pred_pc = '0; upd_valid = 1'b0;
    upd_pc = '0; upd_taken = 1'b0; upd_snap = '0;
    for (int i = 0; i < NLH; i++) begin m_lh[i] = 0; per_idx_cnt[i] = 0; end
    for (int i = 0; i < NLC; i++) m_lc[i] = (1 << (LCTR_W - 1)) - 1;
    for (int i = 0; i < NG; i++) begin
      m_gc[i] = (1 << (GCTR_W - 1)) - 1;
      m_ch[i] = (1 << (SEL_W - 1)) - 1;
    end
    m_gh = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state over every local history slot, no requests
    for (int i = 0; i < NLH; i++) begin
      @(negedge clk);
      pred_pc = PC_W'(i << 2);
      #1;
      chk("R1 pred_taken", int'(pred_taken), 0);
      chk("R1 snapshot", int'(pred_snap), 0);
    end

    // main sweep: requests with delayed updates over patterned outcomes
    for (int c = 0; c < 4000; c++) begin
      int idx, pc, tk;
      bit pv;
      idx = int'($urandom_range(NLH - 1, 0));
      pc  = (int'($urandom_range(7, 0)) << (LIDX_W + 2)) | (idx << 2) | int'($urandom_range(3, 0));
      pv  = ($urandom_range(7, 0) != 0);
      tk  = outcome_for(idx);
      if (pv) per_idx_cnt[idx]++;
      run_cycle(pv, pc, tk, (q_cnt > 3) || ($urandom_range(3, 0) == 0));
    end

    // R7: updates alone leave the global history unchanged
    while (q_cnt > 0) run_cycle(1'b0, 0, 0, 1'b1);

    // R9: directed same-cycle predict and update on one branch
    for (int k = 0; k < 6; k++) begin
      run_cycle(1'b1, 5 << 2, 1, 1'b0);
      run_cycle(1'b1, 5 << 2, 1, 1'b1);
    end
    while (q_cnt > 0) run_cycle(1'b0, 5 << 2, 0, 1'b1);

    // R8: read back every local history after training
    for (int i = 0; i < NLH; i++) begin
      @(negedge clk);
      pred_valid = 1'b0; upd_valid = 1'b0;
      pred_pc = PC_W'(i << 2);
      #1;
      chk("R8 local history", (int'(pred_snap) >> 2) & (NLC - 1), m_lh[i]);
    end

    done = 1;
    finish_run();
  end
endmodule